// File: doc/BRIEF.md
# Staged Reset Sequencer

This block turns a set of reset requests into three staged reset domains. The always-on domain covers the logic that stays powered through deep low-power states. The flash domain covers only the flash memory. The main domain covers everything else. The block also drives a shared open-drain reset pad low, and it issues a start pulse to the flash controller. The main domain leaves reset only after two things have happened: the flash controller has reported that it is ready, and the pad has been seen high again. An external device that keeps the pad low therefore holds the chip in reset.

There are two kinds of request. A full request comes from any bit of `src_req`, or from the pad being pulled low while the chip is running. A low-leakage wakeup on `lp_wake` is a partial request: it resets the flash and main domains but leaves the always-on domain alone, and it does not touch the pad. The power-on reset (`rst_n`) counts as a full request. A single option bit, `pin_en`, turns the reset function of the pad on or off.

Top module: `rst_stage_ctrl`

## Requirements
- R1: While `rst_n` is low, `aon_rst`, `flash_rst` and `chip_rst` are 1 and `pin_pull_lo` and `flash_start` are 0. After release, a full sequence runs and ends with all three reset outputs at 0.
- R2: A full request asserts all three domains. A full request is any `src_req` bit at 1, or, while `pin_en`=1 and the chip is running, a low level on `pin_in` seen through the synchronizer. `aon_rst` then stays high for exactly MIN_LOW cycles and negates together with `flash_rst`.
- R3: A `lp_wake` pulse with no full request asserts `flash_rst` and `chip_rst`. `aon_rst` and `pin_pull_lo` stay 0 for the whole sequence.
- R4: Whenever `aon_rst` is 1, `flash_rst` and `chip_rst` are also 1. Whenever `chip_rst` is 0, `flash_rst` is also 0.
- R5: `flash_rst` negates after MIN_LOW cycles in the assertion stage. `flash_start` is then a single-cycle pulse in the cycle after the first cycle in which `flash_rst` is low.
- R6: For a full request with `pin_en`=1, `pin_pull_lo` stays high for at least MIN_LOW cycles, and until `flash_done` has been accepted after the start pulse.
- R7: `chip_rst` negates only after `flash_done` is accepted and, when `pin_en`=1, after the synchronized pad is seen high. An external low on the pad extends `chip_rst`, and `chip_rst` falls at most 3 cycles after the pad goes high.
- R8: With `pin_en`=0, `pin_pull_lo` stays 0, a low pad does not start a reset, and `chip_rst` negates without waiting for the pad.
- R9: A new request arriving mid-sequence restarts the assertion stage with its counter cleared. A `lp_wake` arriving during a full sequence keeps the sequence full, so `aon_rst` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| src_req | input | N_SRC | Full reset request lines, active high |
| lp_wake | input | 1 | Low-leakage wakeup request (partial reset) |
| flash_done | input | 1 | Flash controller reports initialization complete |
| pin_in | input | 1 | Raw level of the reset pad |
| pin_en | input | 1 | 1 enables the reset function of the pad |
| aon_rst | output | 1 | Always-on domain reset, active high |
| flash_rst | output | 1 | Flash domain reset, active high |
| chip_rst | output | 1 | Main domain reset, active high |
| pin_pull_lo | output | 1 | 1 pulls the reset pad low |
| flash_start | output | 1 | One-cycle flash initialization start pulse |

## Verification
The hardest situations to reach are those where the pad is the only thing holding reset, and those where requests overlap an ongoing sequence. For the pad case, the bench holds the pad low from the running state. That one action both starts a full reset through the pad and keeps the pad low long after the block has released it, so the cycle in which `chip_rst` falls can be compared with the moment of release. For overlap, the bench fires a second full request and a wakeup partway through the assertion stage and checks that the stage lengths start counting again. A flash model with a programmable latency stretches the flash phase, so that the completion condition, not the 128-cycle minimum, decides when the pad is released.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASSERT,
    ST_FLASH_INIT,
    ST_WAIT_PIN_HIGH,
    ST_RUN
  } seq_state_t;
endpackage

// File: rtl/rs_sync2.sv
// Two-stage synchronizer for the pad level.
module rs_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/rs_hold_cnt.sv
// Counts cycles spent in the assertion stage; done on the last one.
module rs_hold_cnt #(
  parameter int MIN_LOW = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CNT_W = (MIN_LOW > 2) ? $clog2(MIN_LOW) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_LOW - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign done = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en && !done)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rs_seq_fsm.sv
// Sequencing state machine with registered reset outputs.
module rs_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic full_req,
  input  logic part_req,
  input  logic pin_high,
  input  logic pin_en,
  input  logic min_done,
  input  logic flash_done,
  output logic cnt_clr,
  output logic cnt_en,
  output logic in_run,
  output logic aon_rst,
  output logic flash_rst,
  output logic chip_rst,
  output logic pin_pull_lo,
  output logic flash_start
);
  seq_state_t state_q, state_d;
  logic full_q, full_d;
  logic started_q, started_d;
  logic aon_q, flash_q, chip_q, pull_q, start_q;
  logic start_d;
  logic any_req;

  assign any_req = full_req | part_req;
  assign in_run  = (state_q == ST_RUN);

  // next-state logic
  always_comb begin
    state_d = state_q;
    full_d  = full_q;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        state_d = ST_ASSERT;
        full_d  = 1'b1;
        cnt_clr = 1'b1;
      end
      ST_ASSERT: begin
        cnt_en = 1'b1;
        if (min_done) state_d = ST_FLASH_INIT;
      end
      ST_FLASH_INIT: begin
        if (started_q && !start_q && flash_done)
          state_d = pin_en ? ST_WAIT_PIN_HIGH : ST_RUN;
      end
      ST_WAIT_PIN_HIGH: begin
        if (!pin_en || pin_high) state_d = ST_RUN;
      end
      ST_RUN: begin
        full_d = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
    // any request restarts from the assertion stage
    if (state_q != ST_IDLE && any_req) begin
      state_d = ST_ASSERT;
      cnt_clr = 1'b1;
      full_d  = (state_q == ST_RUN) ? full_req : (full_q | full_req);
    end
  end

  assign start_d   = (state_q == ST_FLASH_INIT) && (state_d == ST_FLASH_INIT) && !started_q;
  assign started_d = (state_d == ST_FLASH_INIT) && (started_q || start_d);

  // state and output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      full_q    <= 1'b1;
      started_q <= 1'b0;
      aon_q     <= 1'b1;
      flash_q   <= 1'b1;
      chip_q    <= 1'b1;
      pull_q    <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      full_q    <= full_d;
      started_q <= started_d;
      aon_q     <= full_d && (state_d inside {ST_IDLE, ST_ASSERT});
      flash_q   <= (state_d inside {ST_IDLE, ST_ASSERT});
      chip_q    <= (state_d != ST_RUN);
      pull_q    <= pin_en && full_d && (state_d inside {ST_ASSERT, ST_FLASH_INIT});
      start_q   <= start_d;
    end
  end

  assign aon_rst     = aon_q;
  assign flash_rst   = flash_q;
  assign chip_rst    = chip_q;
  assign pin_pull_lo = pull_q;
  assign flash_start = start_q;
endmodule

// File: rtl/rst_stage_ctrl.sv
// Top: staged reset sequencer with a shared reset pad.
module rst_stage_ctrl #(
  parameter int N_SRC   = 4,
  parameter int MIN_LOW = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic             lp_wake,
  input  logic             flash_done,
  input  logic             pin_in,
  input  logic             pin_en,
  output logic             aon_rst,
  output logic             flash_rst,
  output logic             chip_rst,
  output logic             pin_pull_lo,
  output logic             flash_start
);
  logic pin_s;
  logic min_done;
  logic cnt_clr;
  logic cnt_en;
  logic in_run;
  logic ext_req;
  logic full_req;

  rs_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_s)
  );

  // R2: pad pulled low by another agent while running is a full request
  assign ext_req  = pin_en && in_run && !pin_s;
  assign full_req = (|src_req) || ext_req;

  rs_hold_cnt #(.MIN_LOW(MIN_LOW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .done  (min_done)
  );

  rs_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_req    (full_req),
    .part_req    (lp_wake),
    .pin_high    (pin_s),
    .pin_en      (pin_en),
    .min_done    (min_done),
    .flash_done  (flash_done),
    .cnt_clr     (cnt_clr),
    .cnt_en      (cnt_en),
    .in_run      (in_run),
    .aon_rst     (aon_rst),
    .flash_rst   (flash_rst),
    .chip_rst    (chip_rst),
    .pin_pull_lo (pin_pull_lo),
    .flash_start (flash_start)
  );
endmodule

// File: rtl/rst_stage_chk.sv
module rst_stage_chk #(
  parameter int MIN_LOW = 128
) (
  input logic clk,
  input logic rst_n,
  input logic aon_rst,
  input logic flash_rst,
  input logic chip_rst,
  input logic pin_pull_lo,
  input logic flash_start,
  input logic pin_en
);
  localparam int RW = $clog2(MIN_LOW + 1);
  logic [RW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_run <= '0;
    else if (!pin_pull_lo)
      low_run <= '0;
    else if (low_run != RW'(MIN_LOW))
      low_run <= low_run + 1'b1;
  end

  // R4
  aon_implies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aon_rst |-> (flash_rst && chip_rst));

  // R4
  chip_after_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_rst |-> !flash_rst);

  // R5
  start_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_start |-> (!flash_rst && !$past(flash_rst)));

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_start |=> !flash_start);

  // R6
  pin_min_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pin_pull_lo) && $past(pin_en)) |-> (low_run >= RW'(MIN_LOW)));

  // R8
  pin_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pin_en) |-> !pin_pull_lo);
endmodule

bind rst_stage_ctrl rst_stage_chk #(.MIN_LOW(MIN_LOW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .aon_rst     (aon_rst),
  .flash_rst   (flash_rst),
  .chip_rst    (chip_rst),
  .pin_pull_lo (pin_pull_lo),
  .flash_start (flash_start),
  .pin_en      (pin_en)
);

// File: tb/test_rst_stage_ctrl.sv
`timescale 1ns/1ps
module test_rst_stage_ctrl;
  localparam int N_SRC   = 4;
  localparam int MIN_LOW = 128;

  logic clk = 1'b0;
  logic rst_n;
  logic [N_SRC-1:0] src_req;
  logic lp_wake;
  logic flash_done;
  logic pin_in;
  logic pin_en;
  logic ext_hold;
  logic aon_rst, flash_rst, chip_rst, pin_pull_lo, flash_start;

  int errors = 0;
  int checks = 0;
  int fl_lat = 8;
  int fl_cnt = 0;

  // watch results
  int w_pull, w_aon, w_ffall, w_start, w_startw, w_chipfall, w_bad;

  always #5 clk = ~clk;

  assign pin_in = !(pin_pull_lo || ext_hold);

  rst_stage_ctrl #(.N_SRC(N_SRC), .MIN_LOW(MIN_LOW)) i_rst_stage_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .lp_wake(lp_wake),
    .flash_done(flash_done), .pin_in(pin_in), .pin_en(pin_en),
    .aon_rst(aon_rst), .flash_rst(flash_rst), .chip_rst(chip_rst),
    .pin_pull_lo(pin_pull_lo), .flash_start(flash_start)
  );

  // flash controller model
  always @(posedge clk) begin
    if (flash_rst) begin
      fl_cnt     <= 0;
      flash_done <= 1'b0;
    end else if (flash_start) begin
      fl_cnt <= fl_lat;
    end else if (fl_cnt > 1) begin
      fl_cnt <= fl_cnt - 1;
    end else if (fl_cnt == 1) begin
      fl_cnt     <= 0;
      flash_done <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic watch(input int limit);
    bit seen = 1'b0;
    bit prev_fl = flash_rst;
    w_pull = 0; w_aon = 0; w_ffall = -1; w_start = -1;
    w_startw = 0; w_chipfall = -1; w_bad = 0;
    for (int n = 0; n < limit; n++) begin
      @(negedge clk);
      if (pin_pull_lo) w_pull++;
      if (aon_rst) w_aon++;
      if (aon_rst && !(flash_rst && chip_rst)) w_bad++;
      if (flash_start) begin w_startw++; w_start = n; end
      if (prev_fl && !flash_rst) w_ffall = n;
      prev_fl = flash_rst;
      if (chip_rst) seen = 1'b1;
      else if (seen) begin w_chipfall = n; break; end
    end
  endtask

  task automatic pulse_src(input int idx);
    src_req[idx] = 1'b1;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic check_idle(input string req);
    check(!aon_rst && !flash_rst && !chip_rst && !pin_pull_lo && !flash_start,
          req, "outputs idle after sequence",
          {aon_rst, flash_rst, chip_rst, pin_pull_lo, flash_start}, 0);
  endtask

  task automatic t_reset_por();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(aon_rst && flash_rst && chip_rst && !pin_pull_lo && !flash_start, "R1",
          "reset-state outputs", {aon_rst, flash_rst, chip_rst, pin_pull_lo, flash_start}, 5'b11100);
    rst_n = 1'b1;
    watch(3000);
    check(w_chipfall > 0, "R1", "power-on sequence completes", w_chipfall, 1);
    check(w_pull >= MIN_LOW, "R6", "pad low cycles after power-on", w_pull, MIN_LOW);
    check(w_ffall >= MIN_LOW, "R5", "flash reset fall cycle", w_ffall, MIN_LOW);
    check(w_start == w_ffall + 1, "R5", "start pulse cycle", w_start, w_ffall + 1);
    check(w_startw == 1, "R5", "start pulse width", w_startw, 1);
    check(w_bad == 0, "R4", "always-on reset without other domains", w_bad, 0);
    @(negedge clk);
    check_idle("R1");
  endtask

  task automatic t_src_full();
    fork
      watch(3000);
      begin @(negedge clk); pulse_src(N_SRC - 1); end
    join
    check(w_aon == MIN_LOW, "R2", "always-on reset length for source request", w_aon, MIN_LOW);
    check(w_pull >= MIN_LOW, "R6", "pad low cycles for source request", w_pull, MIN_LOW);
    check(w_start == w_ffall + 1, "R5", "start follows flash reset fall", w_start, w_ffall + 1);
    check(w_chipfall > w_start, "R7", "main reset after flash start", w_chipfall, w_start + 1);
    check_idle("R2");
  endtask

  task automatic t_lp_wake();
    fork
      watch(3000);
      begin @(negedge clk); lp_wake = 1'b1; @(negedge clk); lp_wake = 1'b0; end
    join
    check(w_aon == 0, "R3", "always-on reset cycles on wakeup", w_aon, 0);
    check(w_pull == 0, "R3", "pad drive cycles on wakeup", w_pull, 0);
    check(w_ffall >= MIN_LOW && w_chipfall > w_ffall, "R3", "flash and main reset sequenced",
          w_chipfall, w_ffall + 1);
  endtask

  task automatic t_slow_flash();
    fl_lat = 300;
    fork
      watch(5000);
      begin @(negedge clk); pulse_src(0); end
    join
    check(w_pull >= MIN_LOW + 300, "R6", "pad held until flash done", w_pull, MIN_LOW + 300);
    check(w_chipfall > w_start + 300, "R7", "main reset waits for flash done", w_chipfall, w_start + 301);
    fl_lat = 8;
  endtask

  task automatic t_ext_hold();
    fork
      watch(3000);
      begin
        @(negedge clk); ext_hold = 1'b1;   // n=0
        repeat (401) @(negedge clk);        // n=401
        ext_hold = 1'b0;
      end
    join
    check(w_aon == MIN_LOW, "R2", "pad-triggered full reset length", w_aon, MIN_LOW);
    check(w_chipfall > 401 && w_chipfall <= 404, "R7", "main reset fall after external release",
          w_chipfall, 404);
    check_idle("R7");
  endtask

  task automatic t_restart();
    fork
      watch(3000);
      begin
        @(negedge clk); pulse_src(1);       // n=0
        repeat (59) @(negedge clk);          // n=60
        pulse_src(2);
      end
    join
    check(w_ffall >= 60 + MIN_LOW, "R9", "flash reset fall after restart", w_ffall, 60 + MIN_LOW);
    check(w_pull >= 60 + MIN_LOW, "R9", "pad low cycles after restart", w_pull, 60 + MIN_LOW);
    fork
      watch(3000);
      begin
        @(negedge clk); pulse_src(0);       // n=0
        repeat (29) @(negedge clk);          // n=30
        lp_wake = 1'b1; @(negedge clk); lp_wake = 1'b0;
      end
    join
    check(w_aon >= 30 + MIN_LOW, "R9", "always-on reset kept through wakeup", w_aon, 30 + MIN_LOW);
    check(w_bad == 0, "R4", "domain nesting during restart", w_bad, 0);
  endtask

  task automatic t_pin_disabled();
    pin_en = 1'b0;
    ext_hold = 1'b1;
    repeat (20) @(negedge clk);
    check(!chip_rst && !aon_rst, "R8", "low pad ignored as request", {aon_rst, chip_rst}, 0);
    fork
      watch(3000);
      begin @(negedge clk); pulse_src(3); end
    join
    check(w_pull == 0, "R8", "pad never driven when disabled", w_pull, 0);
    check(w_chipfall > 0, "R8", "main reset negates with pad low", w_chipfall, 1);
    ext_hold = 1'b0;
    repeat (5) @(negedge clk);
    pin_en = 1'b1;
    repeat (5) @(negedge clk);
    check_idle("R8");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_req = '0; lp_wake = 1'b0; pin_en = 1'b1; ext_hold = 1'b0;
    flash_done = 1'b0;
    @(negedge clk);
    t_reset_por();
    t_src_full();
    t_lp_wake();
    t_slow_flash();
    t_ext_hold();
    t_restart();
    t_pin_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule